// File: doc/BRIEF.md
# Display Panel Power-Up Sequencer

This block brings a display panel driver out of power-up with no processor involved. A start pulse begins the sequence. The block first runs a timed reset pulse on the panel's reset line. It then walks a fixed table of register writes and sends each one over a write-only three-wire serial link. Some entries carry a settling delay in milliseconds, which the block observes before it moves on. When the last entry has gone out, the block raises a display-enable line and signals completion.

Each table entry becomes two serial transfers, and each transfer is framed by its own chip-select assertion. The first transfer selects the register and the second carries the 16-bit value. All timing comes from one millisecond tick, which is derived from the system clock frequency parameter. The serial clock rate is set by a half-period divider parameter.

Top module: `panel_init_seq`

## Requirements
- R1: Every transfer is 24 bits long and is sent most significant bit first. `cs_n` is low for the whole transfer. `sclk` idles low and pulses only while `cs_n` is low. `sdo` changes only while `sclk` is low, so it is stable on each rising edge.
- R2: For each entry, the register-select transfer carries 0x74, then 0x00, then the 8-bit register number. This is the 24-bit word {8'h74, 8'h00, reg}.
- R3: The register-select transfer of an entry always comes before its value transfer, and the two use separate `cs_n` assertions. The value transfer carries 0x76, then the value's upper byte, then its lower byte.
- R4: The table holds 38 entries and is sent in order. The first entry writes 0x0000 to register 0x07. Nonzero delays of 10, 50, 200 and 30 ms sit on entries 1, 5, 7 and 33 (counting from 0). The full list is `panel_init_pkg::rom_entry`, packed as {reg[7:0], value[15:0], delay_ms[7:0]}.
- R5: After the value transfer of an entry with a nonzero delay d, `cs_n` stays high for at least d ms before the next transfer starts.
- R6: After start, `panel_rst_n` stays high for 100 ms, then goes low for 20 ms, then returns high. The first transfer begins no sooner than 20 ms after that.
- R7: Between any two consecutive transfers, `cs_n` stays high for at least one serial clock period.
- R8: `disp_en` and `done` rise together after the last transfer has ended. `disp_en` is never high while `cs_n` is low.
- R9: A start pulse that arrives while a sequence is running is ignored. The running sequence is neither restarted nor disturbed.
- R10: `done` stays high until the next start. That start clears `done` and `disp_en` on the following cycle and runs the whole sequence again.
- R11: Out of reset, `cs_n` is high, `sclk` is low, `panel_rst_n` is high, and `done` and `disp_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins the sequence |
| done | output | 1 | High once the sequence has finished |
| sclk | output | 1 | Serial clock, idles low |
| sdo | output | 1 | Serial data, most significant bit first |
| cs_n | output | 1 | Active-low chip select, one assertion per transfer |
| panel_rst_n | output | 1 | Panel hardware reset line |
| disp_en | output | 1 | Display enable, raised after the table |

## Verification
A wrong table index or prefix selection appears at once as a wrong 24-bit word in the decoded transfer. A bad bit counter shows up within a single transfer as a frame that is not 24 bits long. A wait counter that loads the wrong value, or that misses the tick mask, shifts the gap before the next falling edge of `cs_n` by whole milliseconds. These gaps are measured against each entry's delay, so the error is caught at the next transfer. A state machine that reacts to a start pulse in mid-run would pull `panel_rst_n` low again or change the transfer count. Both are checked before `done` rises.

// File: rtl/panel_init_pkg.sv
package panel_init_pkg;

   localparam int unsigned SEQ_LEN = 38;
   localparam int unsigned IDX_W   = $clog2(SEQ_LEN);
   localparam int unsigned FRAME_W = 24;
   localparam logic [15:0] SEL_PREFIX = 16'h7400;
   localparam logic [7:0]  VAL_PREFIX = 8'h76;

   typedef struct packed {
      logic [7:0]  addr;
      logic [15:0] val;
      logic [7:0]  dly_ms;
   } entry_t;

   // Packed word layout: {addr, value, delay_ms}
   function automatic entry_t rom_entry(input logic [IDX_W-1:0] i);
      logic [31:0] w;
      case (i)
         6'd0:  w = 32'h07_0000_00;
         6'd1:  w = 32'h13_0000_0A;
         6'd2:  w = 32'h11_3004_00;
         6'd3:  w = 32'h14_200F_00;
         6'd4:  w = 32'h10_1A20_00;
         6'd5:  w = 32'h13_0040_32;
         6'd6:  w = 32'h13_0060_00;
         6'd7:  w = 32'h13_0070_C8;
         6'd8:  w = 32'h01_0127_00;
         6'd9:  w = 32'h02_0700_00;
         6'd10: w = 32'h03_1030_00;
         6'd11: w = 32'h08_0208_00;
         6'd12: w = 32'h0B_0620_00;
         6'd13: w = 32'h0C_0110_00;
         6'd14: w = 32'h30_0120_00;
         6'd15: w = 32'h31_0127_00;
         6'd16: w = 32'h32_0000_00;
         6'd17: w = 32'h33_0503_00;
         6'd18: w = 32'h34_0727_00;
         6'd19: w = 32'h35_0124_00;
         6'd20: w = 32'h36_0706_00;
         6'd21: w = 32'h37_0701_00;
         6'd22: w = 32'h38_0F00_00;
         6'd23: w = 32'h39_0F00_00;
         6'd24: w = 32'h40_0000_00;
         6'd25: w = 32'h41_0000_00;
         6'd26: w = 32'h42_013F_00;
         6'd27: w = 32'h43_0000_00;
         6'd28: w = 32'h44_013F_00;
         6'd29: w = 32'h45_0000_00;
         6'd30: w = 32'h46_EF00_00;
         6'd31: w = 32'h47_013F_00;
         6'd32: w = 32'h48_0000_00;
         6'd33: w = 32'h07_0015_1E;
         6'd34: w = 32'h07_0017_00;
         6'd35: w = 32'h20_0000_00;
         6'd36: w = 32'h21_0000_00;
         6'd37: w = 32'h22_0000_00;
         default: w = 32'h0;
      endcase
      return entry_t'(w);
   endfunction

endpackage

// File: rtl/pinit_tick.sv
module pinit_tick #(
   parameter int unsigned CYCLES = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic tick
);
   if (CYCLES < 1) begin : g_bad_cycles
      $error("pinit_tick: CYCLES must be at least 1");
   end

   if (CYCLES == 1) begin : g_direct
      assign tick = !clr;
   end else begin : g_count
      localparam int unsigned CW = $clog2(CYCLES);
      localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                  cnt <= '0;
         else if (clr || cnt == LAST) cnt <= '0;
         else                         cnt <= cnt + 1'b1;
      end

      // masked during the restart cycle so a fresh wait never sees a stale tick
      assign tick = (cnt == LAST) && !clr;
   end
endmodule

// File: rtl/pinit_serial_tx.sv
module pinit_serial_tx #(
   parameter int unsigned HALF    = 4,
   parameter int unsigned FRAME_W = 24
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               go,
   input  logic [FRAME_W-1:0] frame,
   output logic               fin,
   output logic               sclk,
   output logic               sdo,
   output logic               cs_n
);
   if (HALF < 1) begin : g_bad_half
      $error("pinit_serial_tx: HALF must be at least 1");
   end

   localparam int unsigned CW = $clog2(2 * HALF + 1);
   localparam int unsigned BW = $clog2(FRAME_W);
   localparam logic [CW-1:0] HALF_END  = CW'(HALF - 1);
   localparam logic [CW-1:0] GUARD_END = CW'(2 * HALF - 1);
   localparam logic [BW-1:0] LAST_BIT  = BW'(FRAME_W - 1);

   typedef enum logic [1:0] {T_IDLE, T_SHIFT, T_GUARD} tstate_t;

   tstate_t            st;
   logic [CW-1:0]      cnt;
   logic [BW-1:0]      bitc;
   logic [FRAME_W-1:0] shreg;

   assign sdo = shreg[FRAME_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= T_IDLE;
         cnt   <= '0;
         bitc  <= '0;
         shreg <= '0;
         sclk  <= 1'b0;
         cs_n  <= 1'b1;
         fin   <= 1'b0;
      end else begin
         fin <= 1'b0;
         case (st)
            T_IDLE: if (go) begin
               shreg <= frame;
               cs_n  <= 1'b0;
               cnt   <= '0;
               bitc  <= '0;
               st    <= T_SHIFT;
            end
            T_SHIFT: if (cnt == HALF_END) begin
               cnt  <= '0;
               sclk <= !sclk;
               if (sclk) begin
                  if (bitc == LAST_BIT) begin
                     cs_n <= 1'b1;
                     st   <= T_GUARD;
                  end else begin
                     bitc  <= bitc + 1'b1;
                     shreg <= {shreg[FRAME_W-2:0], 1'b0};
                  end
               end
            end else begin
               cnt <= cnt + 1'b1;
            end
            T_GUARD: if (cnt == GUARD_END) begin
               cnt <= '0;
               fin <= 1'b1;
               st  <= T_IDLE;
            end else begin
               cnt <= cnt + 1'b1;
            end
            default: st <= T_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/panel_init_seq.sv
module panel_init_seq #(
   parameter int unsigned CLK_HZ    = 50_000_000,
   parameter int unsigned SCLK_HALF = 8,
   parameter int unsigned RST_HI_MS = 100,
   parameter int unsigned RST_LO_MS = 20,
   parameter int unsigned SETTLE_MS = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic done,
   output logic sclk,
   output logic sdo,
   output logic cs_n,
   output logic panel_rst_n,
   output logic disp_en
);
   import panel_init_pkg::*;

   localparam int unsigned TICK_CYCLES = CLK_HZ / 1000;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SEQ_LEN - 1);

   if (CLK_HZ % 1000 != 0 || CLK_HZ < 1000) begin : g_bad_clk
      $error("panel_init_seq: CLK_HZ must be a nonzero multiple of 1000");
   end
   if (RST_HI_MS < 1 || RST_HI_MS > 255 || RST_LO_MS < 1 || RST_LO_MS > 255 ||
       SETTLE_MS < 1 || SETTLE_MS > 255) begin : g_bad_ms
      $error("panel_init_seq: reset waits must lie in 1..255 ms");
   end

   typedef enum logic [2:0] {
      S_IDLE, S_RST_HI, S_RST_LO, S_SETTLE, S_SEL, S_VAL, S_WAIT, S_DONE
   } sstate_t;

   sstate_t          st;
   logic [IDX_W-1:0] idx;
   logic [7:0]       ms_left;
   logic             tick_clr, tick;
   logic             tx_go, tx_fin;
   logic [FRAME_W-1:0] tx_frame;
   entry_t           cur, nxt;
   logic             ms_last;

   assign cur     = rom_entry(idx);
   assign nxt     = rom_entry(IDX_W'(idx + 1'b1));
   assign ms_last = tick && (ms_left == 8'd1);

   pinit_tick #(.CYCLES(TICK_CYCLES)) u_tick (
      .clk(clk), .rst_n(rst_n), .clr(tick_clr), .tick(tick)
   );

   pinit_serial_tx #(.HALF(SCLK_HALF), .FRAME_W(FRAME_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .go(tx_go), .frame(tx_frame),
      .fin(tx_fin), .sclk(sclk), .sdo(sdo), .cs_n(cs_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= S_IDLE;
         idx         <= '0;
         ms_left     <= '0;
         tick_clr    <= 1'b0;
         tx_go       <= 1'b0;
         tx_frame    <= '0;
         panel_rst_n <= 1'b1;
         disp_en     <= 1'b0;
         done        <= 1'b0;
      end else begin
         tick_clr <= 1'b0;
         tx_go    <= 1'b0;
         case (st)
            S_IDLE, S_DONE: if (start) begin
               done        <= 1'b0;
               disp_en     <= 1'b0;
               panel_rst_n <= 1'b1;
               ms_left     <= 8'(RST_HI_MS);
               tick_clr    <= 1'b1;
               st          <= S_RST_HI;
            end
            S_RST_HI: if (ms_last) begin
               panel_rst_n <= 1'b0;
               ms_left     <= 8'(RST_LO_MS);
               tick_clr    <= 1'b1;
               st          <= S_RST_LO;
            end else if (tick) begin
               ms_left <= ms_left - 1'b1;
            end
            S_RST_LO: if (ms_last) begin
               panel_rst_n <= 1'b1;
               ms_left     <= 8'(SETTLE_MS);
               tick_clr    <= 1'b1;
               st          <= S_SETTLE;
            end else if (tick) begin
               ms_left <= ms_left - 1'b1;
            end
            S_SETTLE: if (ms_last) begin
               idx      <= '0;
               tx_frame <= {SEL_PREFIX, rom_entry('0).addr};
               tx_go    <= 1'b1;
               st       <= S_SEL;
            end else if (tick) begin
               ms_left <= ms_left - 1'b1;
            end
            S_SEL: if (tx_fin) begin
               tx_frame <= {VAL_PREFIX, cur.val};
               tx_go    <= 1'b1;
               st       <= S_VAL;
            end
            S_VAL, S_WAIT: begin
               if ((st == S_VAL && tx_fin && cur.dly_ms != 8'd0)) begin
                  ms_left  <= cur.dly_ms;
                  tick_clr <= 1'b1;
                  st       <= S_WAIT;
               end else if ((st == S_VAL && tx_fin) || (st == S_WAIT && ms_last)) begin
                  if (idx == LAST_IDX) begin
                     done    <= 1'b1;
                     disp_en <= 1'b1;
                     st      <= S_DONE;
                  end else begin
                     idx      <= IDX_W'(idx + 1'b1);
                     tx_frame <= {SEL_PREFIX, nxt.addr};
                     tx_go    <= 1'b1;
                     st       <= S_SEL;
                  end
               end else if (st == S_WAIT && tick) begin
                  ms_left <= ms_left - 1'b1;
               end
            end
            default: st <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/panel_init_chk.sv
module panel_init_chk (
   input logic clk,
   input logic rst_n,
   input logic done,
   input logic sclk,
   input logic sdo,
   input logic cs_n,
   input logic panel_rst_n,
   input logic disp_en
);
   assert_sclk_framed_R1: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sclk);

   assert_sdo_steady_R1: assert property (@(posedge clk) disable iff (!rst_n)
      sclk |-> $stable(sdo));

   assert_cs_opens_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n) |-> !sclk);

   assert_no_xfer_in_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !panel_rst_n |-> cs_n);

   assert_enable_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      disp_en |-> cs_n);

   assert_done_with_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> disp_en);

   assert_enable_after_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(disp_en) |-> $past(cs_n));

   assert_cs_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |=> cs_n);
endmodule

bind panel_init_seq panel_init_chk u_panel_init_chk (
   .clk(clk), .rst_n(rst_n), .done(done), .sclk(sclk), .sdo(sdo),
   .cs_n(cs_n), .panel_rst_n(panel_rst_n), .disp_en(disp_en)
);

// File: tb/test_panel_init_seq.sv
module test_panel_init_seq;
   localparam int TK = 20;
   localparam int H  = 2;
   localparam int NE = 38;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic done, sclk, sdo, cs_n, panel_rst_n, disp_en;

   int tests = 0;
   int fails = 0;
   int cyc = 0;

   always #2 clk = !clk;
   always @(posedge clk) cyc <= cyc + 1;

   panel_init_seq #(.CLK_HZ(TK * 1000), .SCLK_HALF(H)) i_panel_init_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .done(done), .sclk(sclk),
      .sdo(sdo), .cs_n(cs_n), .panel_rst_n(panel_rst_n), .disp_en(disp_en)
   );

   // expected table {reg, value, delay_ms}
   function automatic logic [31:0] exp_entry(input int i);
      logic [31:0] t [NE] = '{
         32'h07000000, 32'h1300000A, 32'h11300400, 32'h14200F00, 32'h101A2000,
         32'h13004032, 32'h13006000, 32'h130070C8, 32'h01012700, 32'h02070000,
         32'h03103000, 32'h08020800, 32'h0B062000, 32'h0C011000, 32'h30012000,
         32'h31012700, 32'h32000000, 32'h33050300, 32'h34072700, 32'h35012400,
         32'h36070600, 32'h37070100, 32'h380F0000, 32'h390F0000, 32'h40000000,
         32'h41000000, 32'h42013F00, 32'h43000000, 32'h44013F00, 32'h45000000,
         32'h46EF0000, 32'h47013F00, 32'h48000000, 32'h0700151E, 32'h07001700,
         32'h20000000, 32'h21000000, 32'h22000000};
      return t[i];
   endfunction

   // frame monitor
   logic [23:0] fr [200];
   int          fb [200];
   int          fall_t [200];
   int          rise_t [200];
   int          nf = 0;
   logic [23:0] sh = '0;
   int          nb = 0;
   int          sclk_err = 0, sdo_err = 0, en_err = 0;
   int          rst_fall_t = 0, rst_rise_t = 0, rst_falls = 0;
   logic        p_cs = 1'b1, p_sclk = 1'b0, p_sdo = 1'b0, p_rst = 1'b1;

   always @(negedge clk) begin
      if (rst_n) begin
         if (p_cs && !cs_n) begin sh = '0; nb = 0; fall_t[nf] = cyc; end
         if (!cs_n && !p_sclk && sclk) begin sh = {sh[22:0], sdo}; nb++; end
         if (cs_n && sclk) sclk_err++;
         if (sclk && p_sclk && sdo !== p_sdo) sdo_err++;
         if (!p_cs && cs_n) begin
            fr[nf] = sh; fb[nf] = nb; rise_t[nf] = cyc;
            if (nf < 199) nf++;
         end
         if (disp_en && !cs_n) en_err++;
         if (p_rst && !panel_rst_n) begin rst_fall_t = cyc; rst_falls++; end
         if (!p_rst && panel_rst_n) rst_rise_t = cyc;
      end
      p_cs = cs_n; p_sclk = sclk; p_sdo = sdo; p_rst = panel_rst_n;
   end

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic pulse_start(output int t0);
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      t0 = cyc;
   endtask

   task automatic wait_done(input int limit);
      int n = 0;
      while (!done && n < limit) begin @(negedge clk); n++; end
      check(done == 1'b1, "R8", "watchdog: done never rose", n, limit);
   endtask

   task automatic check_run(input int base, input int t0, input int falls0);
      logic [31:0] e;
      int lo, hi, gap, d;
      check(rst_falls == falls0 + 1, "R9", "reset pulses in run", rst_falls, falls0 + 1);
      check(rst_fall_t - t0 >= 100 * TK && rst_fall_t - t0 <= 100 * TK + 4,
            "R6", "reset high time", rst_fall_t - t0, 100 * TK);
      check(rst_rise_t - rst_fall_t >= 20 * TK && rst_rise_t - rst_fall_t <= 20 * TK + 4,
            "R6", "reset low time", rst_rise_t - rst_fall_t, 20 * TK);
      check(fall_t[base] - rst_rise_t >= 20 * TK && fall_t[base] - rst_rise_t <= 20 * TK + 4,
            "R6", "settle before first frame", fall_t[base] - rst_rise_t, 20 * TK);
      check(nf - base == 2 * NE, "R4", "frame count", nf - base, 2 * NE);
      for (int i = 0; i < NE; i++) begin
         e = exp_entry(i);
         // R2: register-select word
         check(fr[base + 2*i] == {8'h74, 8'h00, e[31:24]}, "R2", $sformatf("select frame %0d", i),
               fr[base + 2*i], {8'h74, 8'h00, e[31:24]});
         // R3: value word follows its select word
         check(fr[base + 2*i + 1] == {8'h76, e[23:8]}, "R3", $sformatf("value frame %0d", i),
               fr[base + 2*i + 1], {8'h76, e[23:8]});
         check(fb[base + 2*i] == 24 && fb[base + 2*i + 1] == 24, "R1",
               $sformatf("bit count entry %0d", i), fb[base + 2*i + 1], 24);
         // R3/R7: separate chip-select windows inside an entry
         gap = fall_t[base + 2*i + 1] - rise_t[base + 2*i];
         check(gap >= 2 * H && gap <= 2 * H + 4, "R7", $sformatf("select-value gap %0d", i),
               gap, 2 * H);
         if (i < NE - 1) begin
            d = int'(e[7:0]);
            gap = fall_t[base + 2*i + 2] - rise_t[base + 2*i + 1];
            lo = d * TK + 2 * H;
            hi = lo + 6;
            if (d != 0)
               check(gap >= lo && gap <= hi, "R5", $sformatf("delay after entry %0d", i), gap, lo);
            else
               check(gap >= 2 * H && gap <= 2 * H + 4, "R7",
                     $sformatf("entry gap %0d", i), gap, 2 * H);
         end
      end
      check(sclk_err == 0, "R1", "sclk pulse outside chip select", sclk_err, 0);
      check(sdo_err == 0, "R1", "sdo moved while sclk high", sdo_err, 0);
      check(en_err == 0, "R8", "enable during transfer", en_err, 0);
      check(disp_en == 1'b1, "R8", "enable with done", disp_en, 1);
   endtask

   initial begin
      int t0, base, f0, wd;
      wd = 0;
      repeat (3) @(negedge clk);
      // R11: reset state
      check(cs_n == 1'b1 && sclk == 1'b0, "R11", "serial idle in reset", {cs_n, sclk}, 2'b10);
      check(panel_rst_n == 1'b1 && done == 1'b0 && disp_en == 1'b0, "R11",
            "control lines in reset", {panel_rst_n, done, disp_en}, 3'b100);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      check(cs_n == 1'b1 && done == 1'b0, "R11", "idle before start", {cs_n, done}, 2'b10);

      // first run, with a stray start mid-sequence (R9)
      base = nf; f0 = rst_falls;
      pulse_start(t0);
      while (nf < base + 9 && wd < 100000) begin @(negedge clk); wd++; end
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      repeat (30) @(negedge clk);
      check(panel_rst_n == 1'b1 && done == 1'b0, "R9", "start ignored mid-run",
            {panel_rst_n, done}, 2'b10);
      wait_done(60000);
      check_run(base, t0, f0);
      repeat (100) @(negedge clk);
      check(done == 1'b1 && nf - base == 2 * NE, "R10", "done holds while idle",
            nf - base, 2 * NE);

      // second run (R10)
      base = nf; f0 = rst_falls;
      pulse_start(t0);
      check(done == 1'b0 && disp_en == 1'b0, "R10", "start clears done and enable",
            {done, disp_en}, 2'b00);
      wait_done(60000);
      check_run(base, t0, f0);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #1_000_000;
      fails++; tests++;
      $display("FAIL R8 watchdog expired: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule